// File: doc/BRIEF.md
# DRAM Impedance Calibration Sequencer

This block sits in a DRAM controller and paces the device's impedance calibration. The calibration trims the device's output driver resistance and its on-die termination against an external precision resistor, nominally 240 ohms. That resistor value is shown here for reference only and has no effect on the logic. When the controller requests a calibration, the sequencer raises a one-cycle command strobe. It then keeps a busy flag high for as long as the device needs to finish, and other traffic must stay off the bus while busy is high.

The length of the window depends on why the calibration is being run. The first calibration after reset uses the long window. A calibration that follows an exit from self-refresh uses the middle window. A routine periodic calibration uses the short window. A request that arrives while a window is running is held and starts the moment that window ends. A synchronous reset aborts any window in progress and forgets any held request.

Top module: `zq_cal_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after any clock edge at which `rst` was high, `zq_cmd`, `busy` and `done` are 0.
- R2: A `cal_req` sampled high while idle makes `zq_cmd` high for exactly one cycle, the cycle after the sampling edge, and `busy` rises in that same cycle.
- R3: The first window started after reset lasts `LEN_INIT` cycles (default 512), whatever the value of `ctx_srx`.
- R4: Any later window whose request carried `ctx_srx`=1 lasts `LEN_SRX` cycles (default 256).
- R5: Any later window whose request carried `ctx_srx`=0 lasts `LEN_PER` cycles (default 64).
- R6: `done` is high for exactly one cycle, which is the last cycle of each window. `busy` is low in the following cycle unless a new window begins there.
- R7: A request sampled while `busy` is high, including one sampled in the last cycle of a window, is held. Its window starts in the cycle right after the current window ends, with a fresh `zq_cmd` and no gap in `busy`. The held window uses the self-refresh length if any request collected during the running window had `ctx_srx`=1.
- R8: Any number of requests collected during one window lead to exactly one further window.
- R9: Reset in the middle of a window ends it at once and discards a held request. The next request after reset gets the `LEN_INIT` window.
- R10: `zq_cmd` is only ever high in the first cycle of a window, with `busy` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_req | input | 1 | Calibration request, sampled each edge |
| ctx_srx | input | 1 | Request follows a self-refresh exit (1) or is periodic (0) |
| zq_cmd | output | 1 | One-cycle calibration command strobe |
| busy | output | 1 | Calibration window in progress, bus held off |
| done | output | 1 | One-cycle pulse on the last cycle of a window |

## Verification
The checker runs on every cycle. It checks that the strobe and the done pulse are one cycle wide and only appear while busy is high. It checks that busy only drops right after a done pulse, that outputs are quiet after a reset edge, and that each window, counted from its strobe, ends at one of the three legal lengths. Some behaviour can only be shown by the bench's scenarios, because the length alone does not reveal it. These are: which length goes with which context, the initialisation override after reset, the carrying of a held request into a seamless second window, the merging of many requests into one, and the loss of a held request at reset.

// File: rtl/zqs_pkg.sv
package zqs_pkg;
  typedef enum logic [1:0] {
    CTX_PER  = 2'd0,
    CTX_SRX  = 2'd1,
    CTX_INIT = 2'd2
  } zq_ctx_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/zqs_ctx_track.sv
module zqs_ctx_track
  import zqs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cal_req,
  input  logic    ctx_srx,
  input  logic    busy,
  input  logic    last,
  output logic    start,
  output zq_ctx_e ctx
);
  logic first_q;   // no window started since reset
  logic pend_q;    // request held during a window
  logic pend_srx_q;
  logic srx_eff;

  assign start   = (cal_req || pend_q) && (!busy || last);
  assign srx_eff = pend_q ? (pend_srx_q || (cal_req && ctx_srx)) : ctx_srx;

  always_comb begin
    if (first_q)      ctx = CTX_INIT;
    else if (srx_eff) ctx = CTX_SRX;
    else              ctx = CTX_PER;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q    <= 1'b1;
      pend_q     <= 1'b0;
      pend_srx_q <= 1'b0;
    end else if (start) begin
      first_q    <= 1'b0;
      pend_q     <= 1'b0;
      pend_srx_q <= 1'b0;
    end else if (cal_req && busy) begin
      pend_q     <= 1'b1;
      pend_srx_q <= pend_srx_q || ctx_srx;
    end
  end
endmodule

// File: rtl/zqs_len_sel.sv
module zqs_len_sel
  import zqs_pkg::*;
#(
  parameter int LEN_INIT = 512,
  parameter int LEN_SRX  = 256,
  parameter int LEN_PER  = 64,
  parameter int CW       = 9
) (
  input  zq_ctx_e       ctx,
  output logic [CW-1:0] len_m1
);
  localparam logic [CW-1:0] INIT_M1 = CW'(LEN_INIT - 1);
  localparam logic [CW-1:0] SRX_M1  = CW'(LEN_SRX - 1);
  localparam logic [CW-1:0] PER_M1  = CW'(LEN_PER - 1);

  always_comb begin
    unique case (ctx)
      CTX_INIT: len_m1 = INIT_M1;
      CTX_SRX:  len_m1 = SRX_M1;
      default:  len_m1 = PER_M1;
    endcase
  end
endmodule

// File: rtl/zqs_win_cnt.sv
module zqs_win_cnt #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] len_m1,
  output logic          cmd,
  output logic          busy,
  output logic          done,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  assign last = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      busy  <= 1'b0;
      cmd   <= 1'b0;
      done  <= 1'b0;
    end else begin
      cmd  <= start;
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= len_m1;
      end else if (busy) begin
        if (cnt_q == '0) begin
          busy <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
          done  <= (cnt_q == CW'(1));
        end
      end
    end
  end
endmodule

// File: rtl/zq_cal_seq.sv
module zq_cal_seq
  import zqs_pkg::*;
#(
  parameter int LEN_INIT = 512,
  parameter int LEN_SRX  = 256,
  parameter int LEN_PER  = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic cal_req,
  input  logic ctx_srx,
  output logic zq_cmd,
  output logic busy,
  output logic done
);
  localparam int LMAX = max3(LEN_INIT, LEN_SRX, LEN_PER);
  localparam int CW   = (LMAX > 2) ? $clog2(LMAX) : 1;

  logic          start;
  logic          last;
  zq_ctx_e       ctx;
  logic [CW-1:0] len_m1;

  zqs_ctx_track u_ctx (
    .clk     (clk),
    .rst     (rst),
    .cal_req (cal_req),
    .ctx_srx (ctx_srx),
    .busy    (busy),
    .last    (last),
    .start   (start),
    .ctx     (ctx)
  );

  zqs_len_sel #(
    .LEN_INIT (LEN_INIT),
    .LEN_SRX  (LEN_SRX),
    .LEN_PER  (LEN_PER),
    .CW       (CW)
  ) u_len (
    .ctx    (ctx),
    .len_m1 (len_m1)
  );

  zqs_win_cnt #(
    .CW (CW)
  ) u_win (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .len_m1 (len_m1),
    .cmd    (zq_cmd),
    .busy   (busy),
    .done   (done),
    .last   (last)
  );
endmodule

// File: rtl/zqs_chk.sv
module zqs_chk #(
  parameter int LEN_INIT = 512,
  parameter int LEN_SRX  = 256,
  parameter int LEN_PER  = 64
) (
  input logic clk,
  input logic rst,
  input logic zq_cmd,
  input logic busy,
  input logic done
);
  int win_cyc;

  always_ff @(posedge clk) begin
    if (rst)         win_cyc <= 0;
    else if (zq_cmd) win_cyc <= 2;
    else if (busy)   win_cyc <= win_cyc + 1;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> (!zq_cmd && !busy && !done));

  // R10
  cmd_in_busy_chk: assert property (@(posedge clk) disable iff (rst) zq_cmd |-> busy);

  // R2
  cmd_single_chk: assert property (@(posedge clk) disable iff (rst) zq_cmd |=> !zq_cmd);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R6
  done_in_busy_chk: assert property (@(posedge clk) disable iff (rst) done |-> busy);

  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> $past(done));

  // R3
  win_len_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !zq_cmd && win_cyc != 0) |->
      (win_cyc == LEN_INIT || win_cyc == LEN_SRX || win_cyc == LEN_PER));
endmodule

bind zq_cal_seq zqs_chk #(
  .LEN_INIT (LEN_INIT),
  .LEN_SRX  (LEN_SRX),
  .LEN_PER  (LEN_PER)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .zq_cmd (zq_cmd),
  .busy   (busy),
  .done   (done)
);

// File: tb/sim_zq_cal_seq.sv
`timescale 1ns/1ps
module sim_zq_cal_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cal_req = 1'b0;
  logic ctx_srx = 1'b0;
  logic zq_cmd, busy, done;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  zq_cal_seq u0 (
    .clk     (clk),
    .rst     (rst),
    .cal_req (cal_req),
    .ctx_srx (ctx_srx),
    .zq_cmd  (zq_cmd),
    .busy    (busy),
    .done    (done)
  );

  // columns: launch srx, extra-request start cycle (0 none), extra length,
  // extra srx, first window length, second window length (0 none)
  localparam int NV = 6;
  localparam int VEC [NV][6] = '{
    '{1,  0,  0, 0, 512,   0},
    '{0,  0,  0, 0,  64,   0},
    '{1,  0,  0, 0, 256,   0},
    '{0, 10,  1, 1,  64, 256},
    '{1,  5, 20, 0, 256,  64},
    '{0, 64,  1, 0,  64,  64}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R3";
      1: return "R5";
      2: return "R4";
      3: return "R7";
      4: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic launch(input bit srx);
    @(negedge clk);
    cal_req = 1'b1;
    ctx_srx = srx;
    @(negedge clk);
    cal_req = 1'b0;
    ctx_srx = 1'b0;
  endtask

  // observe one or two back-to-back windows, first cycle already visible
  task automatic watch(input string tag, input int mid_at, input int mid_len,
                       input bit mid_srx, input int w1, input int w2);
    int n;
    int tot;
    bit e_cmd, e_done;
    n = 0;
    tot = w1 + w2;
    chk(busy === 1'b1, "R2", busy, 1);
    while (busy === 1'b1 && n < tot + 4) begin
      n++;
      e_cmd  = (n == 1) || (w2 != 0 && n == w1 + 1);
      e_done = (n == w1) || (w2 != 0 && n == tot);
      chk(zq_cmd === e_cmd, (n == 1) ? "R2" : "R7", zq_cmd, e_cmd);
      chk(done === e_done, "R6", done, e_done);
      if (mid_at != 0 && n >= mid_at && n < mid_at + mid_len) begin
        cal_req = 1'b1;
        ctx_srx = mid_srx;
      end else begin
        cal_req = 1'b0;
        ctx_srx = 1'b0;
      end
      @(negedge clk);
    end
    cal_req = 1'b0;
    chk(n == tot, tag, n, tot);
    chk(done === 1'b0 && zq_cmd === 1'b0, "R6", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(zq_cmd === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0, "R1", busy, 0);

    for (int i = 0; i < NV; i++) begin
      launch(VEC[i][0][0]);
      watch(vec_tag(i), VEC[i][1], VEC[i][2], VEC[i][3][0], VEC[i][4], VEC[i][5]);
      repeat (3) @(negedge clk);
    end

    // R9: abort a running window
    launch(1'b0);
    repeat (29) @(negedge clk);
    chk(busy === 1'b1, "R9", busy, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && zq_cmd === 1'b0, "R9", busy, 0);
    @(negedge clk);
    chk(busy === 1'b0, "R1", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    launch(1'b0);
    watch("R9", 0, 0, 1'b0, 512, 0);

    // R9: held request lost at reset
    launch(1'b0);
    @(negedge clk);
    cal_req = 1'b1;
    ctx_srx = 1'b1;
    @(negedge clk);
    cal_req = 1'b0;
    ctx_srx = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    begin
      int seen;
      seen = 0;
      repeat (600) begin
        @(negedge clk);
        if (busy === 1'b1 || zq_cmd === 1'b1) seen++;
      end
      chk(seen == 0, "R9", seen, 0);
    end

    // R3: first request after reset ignores srx=1 and srx=0 alike
    launch(1'b1);
    watch("R3", 0, 0, 1'b0, 512, 0);
    repeat (2) @(negedge clk);
    launch(1'b0);
    watch("R5", 0, 0, 1'b0, 64, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule